// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent down-counters behind one word-wide register port. Both counters share a single control word that carries a run bit and an auto-reload bit for each counter. Each counter has a reload register and a live count register, and software may write either at any time. On every clock, a running counter decrements by one. When it reaches zero, it either reloads and continues (periodic mode) or stops at zero after one event (one-shot mode).

Timer 0 usually serves as a free-running timestamp. It is loaded with all ones, runs in auto-reload mode, and has its interrupt masked. Software inverts the read value to get a rising count. Timer 1 serves as the event timer in either mode.

Expiries are collected in a cause register and gated by a mask register. The masked result drives one registered interrupt line. Software acknowledges an event by writing zero to the matching cause bit.

Top module: `twin_down_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The register map is as follows, with unmapped offsets reading 0:
  - control at 0x000: bit 0 = timer 0 run, bit 1 = timer 0 auto-reload, bit 2 = timer 1 run, bit 3 = timer 1 auto-reload; other bits read 0.
  - timer 0: reload at 0x010, count at 0x014.
  - timer 1: reload at 0x018, count at 0x01C.
  - cause at 0x110 and mask at 0x114: bit 1 = timer 0, bit 2 = timer 1; other bits read 0.
- R3: A running counter that is not at zero reads one less after each clock. For a free-running count started at 0xFFFFFFFF, the bitwise inverse of the read value equals the number of clocks elapsed.
- R4: A counter whose run bit is clear holds its value.
- R5: With auto-reload set, a counter at zero loads its reload value on the next clock. A reload value of N gives a count sequence with a period of N+1 clocks.
- R6: With auto-reload clear, a counter at zero produces exactly one expiry and then stays at zero. Writing its count register re-arms it.
- R7: An expiry sets the counter's cause bit regardless of the mask. The cause bit reads set on the clock after the expiry.
- R8: Writing the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. An expiry in the same cycle as a clear keeps the bit set.
- R9: `irq_o` is a registered OR of (cause AND mask). It follows a change in cause or mask one clock later, and a masked source never raises it.
- R10: A write to a count register takes effect on the next clock edge, even while the counter runs. Reads return the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| we_i | input | 1 | Write strobe for `wdata_i` at `addr_i` |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered, masked interrupt request |

## Verification
Most wrong internal states show up at the count registers within one clock, because every read returns the live counter. Examples are a lost decrement, a reload from the wrong source, or a one-shot counter that re-arms by itself. The bench walks periodic sequences for several reload values and checks every cycle. A fault in the cause or mask path shows up at `irq_o` exactly one clock after the cause changes. A fault in clear priority shows up the cycle after an acknowledge that races a per-cycle expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL     = 32'h000;
  localparam int unsigned OFF_TMR_BASE = 32'h010;
  localparam int unsigned TMR_STRIDE   = 32'h008;
  localparam int unsigned OFF_RELOAD   = 32'h000;
  localparam int unsigned OFF_VALUE    = 32'h004;
  localparam int unsigned OFF_CAUSE    = 32'h110;
  localparam int unsigned OFF_MASK     = 32'h114;
  localparam int unsigned IRQ_BIT_BASE = 1;

  function automatic int unsigned reload_off(input int unsigned idx);
    return OFF_TMR_BASE + TMR_STRIDE * idx + OFF_RELOAD;
  endfunction

  function automatic int unsigned value_off(input int unsigned idx);
    return OFF_TMR_BASE + TMR_STRIDE * idx + OFF_VALUE;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic             reload_we_i,
  input  logic             value_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] value_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_i && at_zero && (auto_i || armed_q);
  assign reload_o = reload_q;
  assign value_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (reload_we_i) begin
      reload_q <= wdata_i;
    end
  end

  // armed_q lets a one-shot counter fire once when it reaches zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (value_we_i) begin
      cnt_q   <= wdata_i;
      armed_q <= 1'b1;
    end else if (run_i) begin
      if (!at_zero) begin
        cnt_q   <= cnt_q - 1'b1;
        armed_q <= 1'b1;
      end else if (auto_i) begin
        cnt_q   <= reload_q;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int DATA_W = 32,
  parameter int NSRC   = 2,
  parameter int BASE   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   expire_i,
  input  logic              cause_we_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cause_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [NSRC-1:0] cause_q, mask_q, wsel, keep;
  logic            irq_q;
  logic            unused_wdata;

  assign wsel         = wdata_i[BASE +: NSRC];
  assign unused_wdata = ^wdata_i;
  assign keep         = cause_we_i ? (cause_q & wsel) : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= keep | expire_i;  // new expiry beats clear
      if (mask_we_i) mask_q <= wsel;
      irq_q   <= |(cause_q & mask_q);
    end
  end

  assign cause_o = DATA_W'(cause_q) << BASE;
  assign mask_o  = DATA_W'(mask_q) << BASE;
  assign irq_o   = irq_q;
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer #(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int NUM_TMR = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  localparam int CTRL_W = 2 * NUM_TMR;

  logic [31:0]        addr_w;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               ctrl_we, cause_we, mask_we;
  logic [NUM_TMR-1:0] reload_we, value_we, expire_w;
  logic [CNT_W-1:0]   cnt_w    [NUM_TMR];
  logic [CNT_W-1:0]   reload_w [NUM_TMR];
  logic [DATA_W-1:0]  cause_w, mask_w;
  logic               unused_wdata;

  assign addr_w       = 32'(addr_i);
  assign ctrl_we      = we_i && (addr_w == OFF_CTRL);
  assign cause_we     = we_i && (addr_w == OFF_CAUSE);
  assign mask_we      = we_i && (addr_w == OFF_MASK);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign reload_we[t] = we_i && (addr_w == reload_off(t));
    assign value_we[t]  = we_i && (addr_w == value_off(t));

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (ctrl_q[2*t]),
      .auto_i     (ctrl_q[2*t+1]),
      .reload_we_i(reload_we[t]),
      .value_we_i (value_we[t]),
      .wdata_i    (wdata_i[CNT_W-1:0]),
      .reload_o   (reload_w[t]),
      .value_o    (cnt_w[t]),
      .expire_o   (expire_w[t])
    );
  end

  tmr_irq #(.DATA_W(DATA_W), .NSRC(NUM_TMR), .BASE(IRQ_BIT_BASE)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire_w),
    .cause_we_i(cause_we),
    .mask_we_i (mask_we),
    .wdata_i   (wdata_i),
    .cause_o   (cause_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_w == OFF_CTRL)  rdata_o = DATA_W'(ctrl_q);
    if (addr_w == OFF_CAUSE) rdata_o = cause_w;
    if (addr_w == OFF_MASK)  rdata_o = mask_w;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (addr_w == reload_off(t)) rdata_o = DATA_W'(reload_w[t]);
      if (addr_w == value_off(t))  rdata_o = DATA_W'(cnt_w[t]);
    end
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_i,
  input logic [3:0]        ctrl_i,
  input logic [CNT_W-1:0]  cnt0_i,
  input logic [CNT_W-1:0]  cnt1_i,
  input logic [CNT_W-1:0]  rl0_i,
  input logic [CNT_W-1:0]  rl1_i,
  input logic [1:0]        exp_i,
  input logic [DATA_W-1:0] cause_i,
  input logic [DATA_W-1:0] mask_i
);
  import tmr_pkg::*;

  logic vwe0, vwe1, cwe;
  logic unused_chk;
  assign vwe0       = we_i && (32'(addr_i) == value_off(0));
  assign vwe1       = we_i && (32'(addr_i) == value_off(1));
  assign cwe        = we_i && (32'(addr_i) == OFF_CAUSE);
  assign unused_chk = ^wdata_i;

  AST_DEC_T0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && cnt0_i != '0 && !vwe0) |=> cnt0_i == $past(cnt0_i) - 1'b1); // R3
  AST_FREEZE_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[2] && !vwe1) |=> $stable(cnt1_i)); // R4
  AST_RELOAD_T0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[1] && cnt0_i == '0 && !vwe0) |=> cnt0_i == $past(rl0_i)); // R5
  AST_RELOAD_T1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[2] && ctrl_i[3] && cnt1_i == '0 && !vwe1) |=> cnt1_i == $past(rl1_i)); // R5
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[2] && !ctrl_i[3] && cnt1_i == '0 && !vwe1) |=> cnt1_i == '0); // R6
  AST_ONESHOT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_i[1] && !ctrl_i[3] && !vwe1) |=> !exp_i[1]); // R6
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_i[1] |=> cause_i[2]); // R7
  AST_CAUSE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cause_i[1]) |-> $past(cwe && !wdata_i[1])); // R8
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(|(cause_i & mask_i))); // R9
  AST_VALUE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vwe1 |=> cnt1_i == $past(wdata_i[CNT_W-1:0])); // R10
endmodule

bind twin_down_timer twin_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_i  (irq_o),
  .ctrl_i (ctrl_q),
  .cnt0_i (cnt_w[0]),
  .cnt1_i (cnt_w[1]),
  .rl0_i  (reload_w[0]),
  .rl1_i  (reload_w[1]),
  .exp_i  (expire_w),
  .cause_i(cause_w),
  .mask_i (mask_w)
);

// File: tb/twin_down_timer_tb.sv
module twin_down_timer_tb;
  localparam logic [8:0] A_CTRL = 9'h000, A_RL0 = 9'h010, A_V0 = 9'h014,
                         A_RL1 = 9'h018, A_V1 = 9'h01C, A_CAUSE = 9'h110,
                         A_MASK = 9'h114;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  twin_down_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v, v0;
    int ns[6] = '{0, 1, 2, 3, 5, 8};

    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_RL0, v);   chk("R1 rl0", v, 0);
    rd(A_V0, v);    chk("R1 v0", v, 0);
    rd(A_RL1, v);   chk("R1 rl1", v, 0);
    rd(A_V1, v);    chk("R1 v1", v, 0);
    rd(A_CAUSE, v); chk("R1 cause", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 0);
    chk("R1 irq", irq_o, 0);

    // R2 map
    wr(A_RL0, 32'h1234_5678); rd(A_RL0, v); chk("R2 rl0", v, 32'h1234_5678);
    wr(A_RL1, 32'hA5A5_0F0F); rd(A_RL1, v); chk("R2 rl1", v, 32'hA5A5_0F0F);
    wr(A_CTRL, 32'hFFFF_FFF0); rd(A_CTRL, v); chk("R2 ctrl upper", v, 0);
    rd(9'h004, v); chk("R2 unmapped 004", v, 0);
    rd(9'h118, v); chk("R2 unmapped 118", v, 0);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); chk("R2 mask bits", v, 32'h6);
    wr(A_MASK, 0);

    // R3 free-running timestamp
    wr(A_V0, 32'hFFFF_FFFF); wr(A_RL0, 32'hFFFF_FFFF); wr(A_CTRL, 32'h3);
    rd(A_V0, v); chk("R3 start", v, 32'hFFFF_FFFF);
    for (int k = 1; k <= 20; k++) begin
      step(1); rd(A_V0, v); chk("R3 inverted", ~v, k);
    end
    chk("R9 masked t0 irq", irq_o, 0);

    // R4 freeze
    wr(A_CTRL, 0); rd(A_V0, v0);
    step(5); rd(A_V0, v); chk("R4 frozen", v, v0);

    // R5 periodic sweep on timer 1
    foreach (ns[i]) begin
      int n = ns[i];
      wr(A_CTRL, 0); wr(A_CAUSE, 0);
      wr(A_RL1, n); wr(A_V1, n); wr(A_CTRL, 32'hC);
      for (int j = 0; j <= 3 * (n + 1); j++) begin
        if (j > 0) step(1);
        rd(A_V1, v); chk("R5 period", v, n - (j % (n + 1)));
      end
      rd(A_CAUSE, v); chk("R7 cause t1", v, 32'h4);
    end

    // R6 one-shot
    wr(A_CTRL, 0); wr(A_CAUSE, 0); wr(A_MASK, 32'h4);
    wr(A_V1, 3); wr(A_CTRL, 32'h4);
    for (int j = 0; j <= 3; j++) begin
      if (j > 0) step(1);
      rd(A_V1, v); chk("R6 countdown", v, 3 - j);
    end
    rd(A_CAUSE, v); chk("R7 not yet", v, 0);
    step(1); rd(A_CAUSE, v); chk("R7 set", v, 32'h4);
    chk("R9 lag", irq_o, 0);
    step(1); chk("R9 irq up", irq_o, 1);
    step(3); rd(A_V1, v); chk("R6 stays zero", v, 0);
    wr(A_CAUSE, 0); rd(A_CAUSE, v); chk("R8 cleared", v, 0);
    chk("R9 irq lag on clear", irq_o, 1);
    step(1); chk("R9 irq down", irq_o, 0);
    step(5); rd(A_CAUSE, v); chk("R6 single event", v, 0);
    wr(A_V1, 2); step(3); rd(A_CAUSE, v); chk("R6 rearm", v, 32'h4);

    // R8 write-one keeps, write-zero clears
    wr(A_CAUSE, 32'hFFFF_FFFF); rd(A_CAUSE, v); chk("R8 keep", v, 32'h4);
    wr(A_CAUSE, 32'hFFFF_FFFB); rd(A_CAUSE, v); chk("R8 clear bit2", v, 0);
    wr(A_CTRL, 0); wr(A_MASK, 0);

    // R8 expiry beats clear
    wr(A_RL0, 0); wr(A_V0, 0); wr(A_CAUSE, 0); wr(A_CTRL, 32'h3);
    wr(A_CAUSE, 0); rd(A_CAUSE, v); chk("R8 expiry wins", v, 32'h2);

    // R9 mask gating
    step(2); chk("R9 masked", irq_o, 0);
    wr(A_MASK, 32'h2); chk("R9 mask lag", irq_o, 0);
    step(1); chk("R9 unmasked", irq_o, 1);
    wr(A_CTRL, 0); wr(A_CAUSE, 0); step(1); chk("R9 drop", irq_o, 0);

    // R10 value write while running
    wr(A_RL1, 100); wr(A_V1, 100); wr(A_CTRL, 32'hC); step(3);
    wr(A_V1, 50); rd(A_V1, v); chk("R10 written", v, 50);
    step(1); rd(A_V1, v); chk("R10 then count", v, 49);

    // R3 largest event delay
    wr(A_CTRL, 0); wr(A_V1, 32'hFFFF_FFFE); wr(A_CTRL, 32'h4);
    step(4); rd(A_V1, v); chk("R3 max delay", v, 32'hFFFF_FFFA);

    finish_run();
  end
endmodule